// File: doc/BRIEF.md
# Sector Erase Command Accumulator

This block is the command-state logic of a flash-style storage array for multi-sector erase. A sector erase command received in read mode queues its sector and opens an acceptance window. Further sector erase commands that arrive while the window is open add their sectors in any order, and each newly queued sector restarts the window. When the window runs out with no new sector, the erase phase begins. The erase phase is modelled as a busy period of `ERASE_CYC` active cycles. At the end of it every word of every queued sector reads as all ones, and the block returns to read mode with the queue emptied.

While the window is open, any command other than sector erase or suspend cancels the whole request. Once erasing, the block obeys only suspend; in the suspended state it obeys only resume. A status read during the window or the erase phase returns a progress word rather than array data. An active-low hardware reset abandons everything at once and leaves the array contents untouched. A small word array with a program command is part of the block, so that the effect of an erase can be seen at the read port.

Top module: `sector_erase_queue`

## Requirements
- R1: After reset the block is in read mode: `busy` is 0 and a read returns the array word one cycle later.
- R2: A sector erase command (`cmd_op` = 1, sector = `cmd_addr` / `WORDS_PER_SECTOR`) in read mode queues that sector and opens the window; `busy` goes to 1 on the next cycle.
- R3: During the window a sector erase command for a sector not yet queued adds it, whatever the order of sectors, and restarts the window count from zero.
- R4: During the window a sector erase command for an already queued sector is ignored: the queue is unchanged and the window count is not restarted.
- R5: The erase phase begins at the clock edge that ends `WINDOW_CYC` consecutive window cycles with no accepted sector; status bit 3 reads 0 in the window and 1 in the erase phase.
- R6: During the window, any command with `cmd_op` other than 1 or 2 cancels the request: `busy` drops, the queue is emptied and no word is erased.
- R7: In the erase phase every command except suspend (`cmd_op` = 2) is ignored; in particular a program (`cmd_op` = 4) leaves the array unchanged.
- R8: Suspend freezes the erase count, and resume (`cmd_op` = 3) continues it; suspend received during the window ends the window and enters the suspended state with the count at zero. The erase completes after `ERASE_CYC` non-suspended erase cycles.
- R9: On completion every word of every queued sector reads as all ones, words of other sectors are unchanged, `busy` returns to 0 and the queue is empty.
- R10: A status read (`rd_en`) during the window or the erase phase returns bit 7 = 0, bit 3 as in R5, all other bits 0, and bit 6 equal to a toggle flag that inverts after every such read and is cleared only by reset.
- R11: In read mode and in the suspended state a read returns the array word at `rd_addr` one cycle later; a program in read mode overwrites the word at `cmd_addr` with `cmd_data`, and a read in the same cycle returns the old value.
- R12: Asserting `rst_n` low during the window or the erase phase aborts at once: `busy` is 0, the queue is emptied and the array keeps its prior contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; a command cycle completes at its rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cmd_valid | input | 1 | A command write occurs this cycle |
| cmd_op | input | 3 | Command code: 1 sector erase, 2 suspend, 3 resume, 4 program, others are plain commands |
| cmd_addr | input | ADDR_W | Word address; its upper bits select the sector |
| cmd_data | input | DATA_W | Program data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Array word or status word, one cycle after `rd_en` |
| busy | output | 1 | High during the window, the erase phase and the suspended state |

## Verification
The hardest case to reach from the ports is a command that coincides with the edge on which the window would run out. A new sector must restart the window, while a repeated sector must let it expire on that same edge. The bench shortens the window and erase lengths through parameters and counts cycles from the last accepted address. It lands repeated and fresh addresses at exact offsets, including the final window cycle. Its per-clock reference model then reveals any off-by-one in the window through `busy` and through status bit 3.

// File: rtl/sea_pkg.sv
package sea_pkg;

   localparam logic [2:0] OP_SECT_ERASE = 3'd1;
   localparam logic [2:0] OP_SUSPEND    = 3'd2;
   localparam logic [2:0] OP_RESUME     = 3'd3;
   localparam logic [2:0] OP_PROGRAM    = 3'd4;

   typedef enum logic [1:0] {
      PH_READ   = 2'd0,
      PH_WINDOW = 2'd1,
      PH_ERASE  = 2'd2,
      PH_HOLD   = 2'd3
   } phase_e;

   localparam int STAT_TOGGLE_BIT = 6;
   localparam int STAT_PHASE_BIT  = 3;
   localparam int STAT_DONE_BIT   = 7;

endpackage

// File: rtl/sea_window_timer.sv
module sea_window_timer #(
   parameter int WINDOW_CYC = 12500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic expired
);
   localparam int CNT_W = $clog2(WINDOW_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   assign expired = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (restart)         cnt_q <= '0;
      else if (run && !expired) cnt_q <= cnt_q + 1'b1;
   end

   // R5: the window count never passes its final cycle
   a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/sea_erase_timer.sv
module sea_erase_timer #(
   parameter int ERASE_CYC = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic done
);
   localparam int CNT_W = $clog2(ERASE_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ERASE_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   assign done = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (start)        cnt_q <= '0;
      else if (run && !done) cnt_q <= cnt_q + 1'b1;
   end

   // R8: while suspended or idle the erase count holds
   a_r8_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start) |=> $stable(cnt_q));

endmodule

// File: rtl/sea_sector_map.sv
module sea_sector_map #(
   parameter int SECTORS = 64,
   localparam int SECT_W = $clog2(SECTORS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               add,
   input  logic [SECT_W-1:0]  add_idx,
   output logic [SECTORS-1:0] map,
   output logic               hit
);
   logic [SECTORS-1:0] map_q;

   assign map = map_q;
   assign hit = map_q[add_idx];

   for (genvar s = 0; s < SECTORS; s++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 map_q[s] <= 1'b0;
         else if (clear)                             map_q[s] <= 1'b0;
         else if (add && (add_idx == SECT_W'(s)))    map_q[s] <= 1'b1;
      end
   end

endmodule

// File: rtl/sea_word_array.sv
module sea_word_array #(
   parameter int SECTORS          = 64,
   parameter int WORDS_PER_SECTOR = 4,
   parameter int DATA_W           = 16,
   localparam int WORDS  = SECTORS * WORDS_PER_SECTOR,
   localparam int ADDR_W = $clog2(WORDS)
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               erase_en,
   input  logic [SECTORS-1:0] erase_map,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_word
);
   logic [DATA_W-1:0] mem [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam int SEC = w / WORDS_PER_SECTOR;
      always_ff @(posedge clk) begin
         if (erase_en && erase_map[SEC])             mem[w] <= '1;
         else if (wr_en && (wr_addr == ADDR_W'(w)))  mem[w] <= wr_data;
      end
   end

   assign rd_word = mem[rd_addr];

endmodule

// File: rtl/sector_erase_queue.sv
module sector_erase_queue #(
   parameter int SECTORS          = 64,
   parameter int WORDS_PER_SECTOR = 4,
   parameter int DATA_W           = 16,
   parameter int WINDOW_CYC       = 12500,
   parameter int ERASE_CYC        = 2000,
   localparam int ADDR_W = $clog2(SECTORS * WORDS_PER_SECTOR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy
);
   import sea_pkg::*;

   localparam int SECT_W = $clog2(SECTORS);
   localparam int WORD_W = $clog2(WORDS_PER_SECTOR);

   // elaboration-time parameter checks
   if (SECTORS < 2 || (1 << SECT_W) != SECTORS) begin : g_bad_sectors
      $error("SECTORS must be a power of two and at least 2");
   end
   if (WORDS_PER_SECTOR < 1 || (1 << WORD_W) != WORDS_PER_SECTOR) begin : g_bad_words
      $error("WORDS_PER_SECTOR must be a power of two");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must hold the status bits");
   end
   if (WINDOW_CYC < 2 || ERASE_CYC < 2) begin : g_bad_timing
      $error("WINDOW_CYC and ERASE_CYC must be at least 2");
   end

   // sector index from the command address
   logic [SECT_W-1:0] sect_idx;
   if (WORDS_PER_SECTOR == 1) begin : g_sect_flat
      assign sect_idx = cmd_addr;
   end else begin : g_sect_split
      assign sect_idx = cmd_addr[ADDR_W-1:WORD_W];
   end

   phase_e phase_q, phase_d;

   logic is_se, is_susp, is_resume, is_prog, is_other;
   assign is_se     = cmd_valid && (cmd_op == OP_SECT_ERASE);
   assign is_susp   = cmd_valid && (cmd_op == OP_SUSPEND);
   assign is_resume = cmd_valid && (cmd_op == OP_RESUME);
   assign is_prog   = cmd_valid && (cmd_op == OP_PROGRAM);
   assign is_other  = cmd_valid && !is_se && !is_susp;

   logic [SECTORS-1:0] map;
   logic               hit;
   logic               map_add, map_clear;
   logic               win_restart, win_run, win_expired;
   logic               er_start, er_run, er_done;
   logic               cancel;

   assign cancel      = (phase_q == PH_WINDOW) && is_other;
   assign map_add     = is_se && !hit &&
                        ((phase_q == PH_READ) || (phase_q == PH_WINDOW));
   assign win_restart = map_add;
   assign win_run     = (phase_q == PH_WINDOW) && !map_add && !is_susp && !cancel;
   assign er_run      = (phase_q == PH_ERASE) && !is_susp;
   assign er_start    = (phase_q == PH_WINDOW) && (is_susp || win_expired);
   assign map_clear   = cancel || er_done;

   sea_window_timer #(.WINDOW_CYC(WINDOW_CYC)) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (win_restart),
      .run     (win_run),
      .expired (win_expired)
   );

   sea_erase_timer #(.ERASE_CYC(ERASE_CYC)) u_erase (
      .clk   (clk),
      .rst_n (rst_n),
      .start (er_start),
      .run   (er_run),
      .done  (er_done)
   );

   sea_sector_map #(.SECTORS(SECTORS)) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (map_clear),
      .add     (map_add),
      .add_idx (sect_idx),
      .map     (map),
      .hit     (hit)
   );

   logic [DATA_W-1:0] arr_word;

   sea_word_array #(
      .SECTORS          (SECTORS),
      .WORDS_PER_SECTOR (WORDS_PER_SECTOR),
      .DATA_W           (DATA_W)
   ) u_array (
      .clk       (clk),
      .wr_en     (is_prog && (phase_q == PH_READ)),
      .wr_addr   (cmd_addr),
      .wr_data   (cmd_data),
      .erase_en  (er_done),
      .erase_map (map),
      .rd_addr   (rd_addr),
      .rd_word   (arr_word)
   );

   // phase sequencing
   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_READ:   if (is_se) phase_d = PH_WINDOW;
         PH_WINDOW: begin
            if (map_add)          phase_d = PH_WINDOW;
            else if (is_susp)     phase_d = PH_HOLD;
            else if (cancel)      phase_d = PH_READ;
            else if (win_expired) phase_d = PH_ERASE;
         end
         PH_ERASE: begin
            if (is_susp)      phase_d = PH_HOLD;
            else if (er_done) phase_d = PH_READ;
         end
         PH_HOLD:   if (is_resume) phase_d = PH_ERASE;
         default:   phase_d = PH_READ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_READ;
      else        phase_q <= phase_d;
   end

   assign busy = (phase_q != PH_READ);

   // read path: status word while the window or erase is running
   logic              status_phase;
   logic              tog_q;
   logic              stat_q;
   logic [DATA_W-1:0] status_word;

   assign status_phase = (phase_q == PH_WINDOW) || (phase_q == PH_ERASE);

   always_comb begin
      status_word                  = '0;
      status_word[STAT_TOGGLE_BIT] = tog_q;
      status_word[STAT_PHASE_BIT]  = (phase_q == PH_ERASE);
      status_word[STAT_DONE_BIT]   = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         tog_q   <= 1'b0;
         stat_q  <= 1'b0;
      end else begin
         stat_q <= rd_en && status_phase;
         if (rd_en) begin
            if (status_phase) begin
               rd_data <= status_word;
               tog_q   <= ~tog_q;
            end else begin
               rd_data <= arr_word;
            end
         end
      end
   end

   // R6: a plain command in the window empties the queue and returns to read mode
   a_r6_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_q == PH_WINDOW) && is_other) |=> ((phase_q == PH_READ) && (map == '0)));

   // R7: the erase phase holds its queue until suspend or completion
   a_r7_erase_locked: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_q == PH_ERASE) && !is_susp && !er_done) |=> ((phase_q == PH_ERASE) && $stable(map)));

   // R9: completion leaves read mode with an empty queue
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_q == PH_ERASE) && er_done && !is_susp) |=> (!busy && (map == '0)));

   // R3: a sector erase command while queuing always leaves its sector queued
   a_r3_sector_queued: assert property (@(posedge clk) disable iff (!rst_n)
      (((phase_q == PH_READ) || (phase_q == PH_WINDOW)) && is_se) |=> map[$past(sect_idx)]);

   // R4: a repeated sector leaves the queue untouched
   a_r4_repeat_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_q == PH_WINDOW) && is_se && hit) |=> $stable(map));

   // R10: status words never report completion
   a_r10_bit7_low: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q |-> (rd_data[STAT_DONE_BIT] == 1'b0));

endmodule

// File: tb/sector_erase_queue_bench.sv
`timescale 1ns/1ps
module sector_erase_queue_bench;
   localparam int SECT  = 64;
   localparam int WPS   = 4;
   localparam int DW    = 16;
   localparam int WIN   = 40;
   localparam int ERC   = 30;
   localparam int WORDS = SECT * WPS;
   localparam int AW    = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_data = '0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          busy;

   always #2 clk = ~clk;

   sector_erase_queue #(
      .SECTORS(SECT), .WORDS_PER_SECTOR(WPS), .DATA_W(DW),
      .WINDOW_CYC(WIN), .ERASE_CYC(ERC)
   ) u_sector_erase_queue (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_req = "R1";

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int            m_ph;      // 0 read, 1 window, 2 erase, 3 suspended
   bit [SECT-1:0] m_map;
   int            m_w, m_e;
   bit            m_tog;
   bit            m_rdv;
   logic [DW-1:0] m_rd;
   logic [DW-1:0] m_mem [WORDS];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_map = '0; m_w = 0; m_e = 0; m_tog = 0; m_rdv = 0;
      end else begin
         int sec;
         sec   = int'(cmd_addr) / WPS;
         m_rdv = rd_en;
         if (rd_en) begin
            if (m_ph == 1 || m_ph == 2) begin
               m_rd = '0;
               m_rd[6] = m_tog;
               m_rd[3] = (m_ph == 2);
               m_tog = !m_tog;
            end else begin
               m_rd = m_mem[rd_addr];
            end
         end
         case (m_ph)
            0: begin
               if (cmd_valid && cmd_op == 3'd1) begin
                  m_map[sec] = 1'b1; m_w = 0; m_ph = 1;
               end else if (cmd_valid && cmd_op == 3'd4) begin
                  m_mem[cmd_addr] = cmd_data;
               end
            end
            1: begin
               if (cmd_valid && cmd_op == 3'd1 && !m_map[sec]) begin
                  m_map[sec] = 1'b1; m_w = 0;
               end else if (cmd_valid && cmd_op == 3'd2) begin
                  m_ph = 3; m_e = 0;
               end else if (cmd_valid && cmd_op != 3'd1) begin
                  m_ph = 0; m_map = '0;
               end else if (m_w == WIN - 1) begin
                  m_ph = 2; m_e = 0;
               end else begin
                  m_w++;
               end
            end
            2: begin
               if (cmd_valid && cmd_op == 3'd2) m_ph = 3;
               else if (m_e == ERC - 1) begin
                  for (int i = 0; i < WORDS; i++)
                     if (m_map[i / WPS]) m_mem[i] = '1;
                  m_map = '0; m_ph = 0;
               end else m_e++;
            end
            default: if (cmd_valid && cmd_op == 3'd3) m_ph = 2;
         endcase
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk({cur_req, " busy"}, 32'(busy), 32'(m_ph != 0));
         if (m_rdv) chk({cur_req, " rd_data"}, 32'(rd_data), 32'(m_rd));
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cmd(logic [2:0] op, int addr, logic [DW-1:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(addr); cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = '0;
   endtask

   task automatic rd(int addr);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = AW'(addr);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (busy && guard < 5000) begin @(negedge clk); guard++; end
   endtask

   bit done_flag = 0;

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      cur_req = "R1";
      chk("R1 reset busy", 32'(busy), 0);

      cur_req = "R11";
      for (int s = 0; s < 12; s++)
         for (int w = 0; w < WPS; w++)
            cmd(3'd4, s * WPS + w, DW'(16'h1000 + s * 16 + w));
      cmd(3'd4, 63 * WPS, 16'h3F00);
      rd(7 * WPS + 2);
      chk("R11 program readback", 32'(rd_data), 32'h1072);

      // queue sectors out of order, repeat one, read status
      cur_req = "R2";
      cmd(3'd1, 7 * WPS + 1, '0);
      chk("R2 busy after first sector", 32'(busy), 1);
      rd(0);
      chk("R10 window bit3", 32'(rd_data[3]), 0);
      rd(0);
      cur_req = "R3";
      idle(10);
      cmd(3'd1, 3 * WPS, '0);
      idle(WIN - 5);
      cmd(3'd1, 63 * WPS + 3, '0);
      cur_req = "R4";
      idle(20);
      cmd(3'd1, 7 * WPS, '0);
      idle(WIN - 24);
      cur_req = "R5";
      idle(6);
      rd(0);
      chk("R5 erase bit3", 32'(rd_data[3]), 1);
      cur_req = "R7";
      cmd(3'd4, 10 * WPS, 16'hDEAD);
      cmd(3'd0, 0, '0);
      cur_req = "R9";
      wait_idle();
      idle(2);
      rd(7 * WPS + 2);
      chk("R9 erased word", 32'(rd_data), 32'hFFFF);
      rd(63 * WPS);
      chk("R9 erased last sector", 32'(rd_data), 32'hFFFF);
      rd(10 * WPS);
      chk("R7 program ignored while erasing", 32'(rd_data), 32'h10A0);
      rd(4 * WPS + 1);
      chk("R9 other sector kept", 32'(rd_data), 32'h1041);

      // repeated sector exactly at the last window cycle must not restart
      cur_req = "R4";
      cmd(3'd1, 5 * WPS, '0);
      idle(WIN - 2);
      cmd(3'd1, 5 * WPS, '0);
      chk("R4 erase on final-cycle repeat", 32'(busy), 1);
      rd(0);
      chk("R4 bit3 after final-cycle repeat", 32'(rd_data[3]), 1);
      wait_idle();

      // new sector at the last window cycle restarts
      cur_req = "R3";
      cmd(3'd1, 8 * WPS, '0);
      idle(WIN - 2);
      cmd(3'd1, 9 * WPS, '0);
      rd(0);
      chk("R3 restart at final cycle bit3", 32'(rd_data[3]), 0);
      wait_idle();

      // cancel in window
      cur_req = "R6";
      cmd(3'd1, 11 * WPS, '0);
      idle(5);
      cmd(3'd0, 0, '0);
      chk("R6 cancelled busy", 32'(busy), 0);
      rd(11 * WPS + 1);
      chk("R6 sector untouched", 32'(rd_data), 32'h10B1);

      // suspend and resume during erase
      cur_req = "R8";
      cmd(3'd1, 11 * WPS, '0);
      idle(WIN + 5);
      cmd(3'd2, 0, '0);
      idle(100);
      chk("R8 still busy while suspended", 32'(busy), 1);
      cur_req = "R11";
      rd(11 * WPS + 2);
      chk("R11 read while suspended", 32'(rd_data), 32'h10B2);
      cur_req = "R8";
      cmd(3'd3, 0, '0);
      wait_idle();
      rd(11 * WPS + 2);
      chk("R8 erase finished after resume", 32'(rd_data), 32'hFFFF);

      // suspend inside the window
      cmd(3'd4, 2 * WPS, 16'h2222);
      cmd(3'd1, 2 * WPS, '0);
      idle(4);
      cmd(3'd2, 0, '0);
      idle(WIN + 10);
      chk("R8 suspended from window", 32'(busy), 1);
      cmd(3'd3, 0, '0);
      wait_idle();
      rd(2 * WPS);
      chk("R8 window-suspend erase done", 32'(rd_data), 32'hFFFF);

      // hardware reset during erase
      cur_req = "R12";
      cmd(3'd4, 6 * WPS, 16'h6060);
      cmd(3'd1, 6 * WPS, '0);
      idle(WIN + 8);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R12 busy after abort", 32'(busy), 0);
      rst_n = 1'b1;
      idle(2);
      rd(6 * WPS);
      chk("R12 data kept after abort", 32'(rd_data), 32'h6060);
      idle(WIN + ERC + 5);
      chk("R12 no erase resumes", 32'(busy), 0);

      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule